// File: doc/BRIEF.md
# Receive Error Detector

This block sits where a serial receiver's shift register hands a finished character to the receive buffer. On every shift-complete strobe it captures the character into the buffer. It then checks three things: the parity bit, the stop bit, and whether software or the reader had finished with the previous character. Each failure raises its own sticky flag and a shared error factor flag. A gated interrupt line follows the shared flag.

Software clears flags by writing ones to them. The received character is always stored, whatever errors it carries, and the receiver never stalls. The overrun rule depends on the operating mode. In asynchronous mode a character is consumed by a receive-trigger write from software. In clock synchronous slave mode it is consumed by a buffer read. In clock synchronous master mode no overrun is ever detected.

Top module: `rxerr_monitor`

## Requirements
- R1: After reset, rx_data is 0 and par_err, frm_err, ovr_err, err_any and err_irq are all 0.
- R2: A shift_done pulse copies shift_data into rx_data, and the new value is visible after that clock edge. This happens whether or not the character has any error.
- R3: In asynchronous mode (mode = 0) with par_en = 1, the block counts the ones in the data bits plus the parity bit. That count must be even when par_odd = 0 and odd when par_odd = 1. If it is not, par_err is set after the transfer edge.
- R4: No parity error is raised when par_en = 0, or when mode is 1 or 3 (synchronous master) or 2 (synchronous slave).
- R5: A transferred character whose shift_stop is 0 sets frm_err after the transfer edge.
- R6: In asynchronous mode, a character that completes with no rx_trig_wr pulse since the previous character sets ovr_err. The first character after reset never does.
- R7: In asynchronous mode, an rx_trig_wr pulse in the same cycle as shift_done does not count as consuming the character. That transfer sets ovr_err.
- R8: In synchronous slave mode, overrun is judged against buf_rd instead of the trigger. A buf_rd in the same cycle as shift_done counts as having read the previous character. In synchronous master mode ovr_err is never set.
- R9: A flag_wr pulse clears each flag whose bit is 1 in flag_wdata. The bit positions are: bit 0 par_err, bit 1 frm_err, bit 2 ovr_err, bit 3 err_any. Bits written as 0 leave their flags unchanged.
- R10: When an error is detected in the same cycle as a clear of its flag, the flag is set.
- R11: Any detected error also sets err_any. err_any is cleared only through its own bit, independently of the individual flags.
- R12: err_irq is high exactly when err_any is 1 and irq_en is 1.
- R13: A character with several errors sets all of the matching flags on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 async, 1/3 sync master, 2 sync slave |
| par_en | input | 1 | Parity checking enable |
| par_odd | input | 1 | 1 odd parity, 0 even parity |
| irq_en | input | 1 | Error interrupt enable |
| shift_done | input | 1 | Shift register holds a complete character |
| shift_data | input | DATA_W | Received data bits |
| shift_stop | input | 1 | Received stop bit |
| shift_par | input | 1 | Received parity bit |
| rx_trig_wr | input | 1 | Software receive-trigger write strobe |
| buf_rd | input | 1 | Receive buffer read strobe |
| flag_wr | input | 1 | Flag clear write strobe |
| flag_wdata | input | 4 | Write-one-to-clear mask |
| rx_data | output | DATA_W | Receive data buffer |
| par_err | output | 1 | Parity error flag |
| frm_err | output | 1 | Framing error flag |
| ovr_err | output | 1 | Overrun error flag |
| err_any | output | 1 | Shared error factor flag |
| err_irq | output | 1 | Gated error interrupt |

## Verification
The bench builds the block with DATA_W = 4, so every data value can be tried. It sweeps all 16 values, both parity bit values, both parity senses, parity enabled and disabled, and all three modes. The stop bit is toggled across the sweep, and the bench computes the expected parity and framing result arithmetically. Directed sequences then cover the overrun handshakes of each mode, including the coincident trigger and read cases, the set-over-clear priority, the partial clears and the interrupt gate.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;

    typedef enum logic [1:0] {
        MODE_ASYNC    = 2'd0,
        MODE_SYNC_MST = 2'd1,
        MODE_SYNC_SLV = 2'd2,
        MODE_SYNC_ALT = 2'd3
    } rx_mode_e;

    localparam int FLAG_W   = 4;
    localparam int FLAG_PAR = 0;
    localparam int FLAG_FRM = 1;
    localparam int FLAG_OVR = 2;
    localparam int FLAG_ANY = 3;

    typedef struct packed {
        logic any;
        logic ovr;
        logic frm;
        logic par;
    } err_flags_t;

endpackage

// File: rtl/rxerr_parity.sv
module rxerr_parity
    import rxerr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              par_bit,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [1:0]        mode,
    output logic              par_bad
);

    localparam int TOT_W = DATA_W + 1;

    logic [TOT_W-1:0] fold;

    // running xor chain over data bits and the parity bit
    assign fold[0] = par_bit;
    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_fold
            assign fold[i+1] = fold[i] ^ data[i];
        end
    endgenerate

    always_comb begin
        par_bad = 1'b0;
        if (par_en && rx_mode_e'(mode) == MODE_ASYNC) begin
            par_bad = (fold[TOT_W-1] != par_odd);
        end
    end

endmodule

// File: rtl/rxerr_overrun.sv
module rxerr_overrun
    import rxerr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       shift_done,
    input  logic       rx_trig_wr,
    input  logic       buf_rd,
    output logic       ovr_hit
);

    typedef struct packed {
        logic consumed;
    } ovr_state_t;

    ovr_state_t st_d, st_q;
    logic       release_ev;

    always_comb begin
        st_d       = st_q;
        ovr_hit    = 1'b0;
        release_ev = 1'b0;
        unique case (rx_mode_e'(mode))
            MODE_ASYNC: begin
                release_ev = rx_trig_wr;
                ovr_hit    = shift_done && (!st_q.consumed || rx_trig_wr);
            end
            MODE_SYNC_SLV: begin
                release_ev = buf_rd;
                ovr_hit    = shift_done && !st_q.consumed && !buf_rd;
            end
            default: begin
                release_ev = buf_rd;
                ovr_hit    = 1'b0;
            end
        endcase
        if (shift_done) begin
            st_d.consumed = 1'b0;
        end else if (release_ev) begin
            st_d.consumed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.consumed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rxerr_flags.sv
module rxerr_flags
    import rxerr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  err_flags_t        set_vec,
    input  logic              flag_wr,
    input  logic [FLAG_W-1:0] flag_wdata,
    output err_flags_t        flags
);

    err_flags_t flags_d, flags_q;
    logic [FLAG_W-1:0] clr_mask;

    always_comb begin
        clr_mask = flag_wr ? flag_wdata : '0;
        for (int i = 0; i < FLAG_W; i++) begin
            // detection wins over a same-cycle clear
            flags_d[i] = set_vec[i] | (flags_q[i] & ~clr_mask[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags = flags_q;

endmodule

// File: rtl/rxerr_monitor.sv
module rxerr_monitor
    import rxerr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              irq_en,
    input  logic              shift_done,
    input  logic [DATA_W-1:0] shift_data,
    input  logic              shift_stop,
    input  logic              shift_par,
    input  logic              rx_trig_wr,
    input  logic              buf_rd,
    input  logic              flag_wr,
    input  logic [3:0]        flag_wdata,
    output logic [DATA_W-1:0] rx_data,
    output logic              par_err,
    output logic              frm_err,
    output logic              ovr_err,
    output logic              err_any,
    output logic              err_irq
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
    } buf_state_t;

    buf_state_t buf_d, buf_q;
    logic       par_bad;
    logic       ovr_hit;
    err_flags_t set_vec;
    err_flags_t flags;

    rxerr_parity #(.DATA_W(DATA_W)) u_parity (
        .data    (shift_data),
        .par_bit (shift_par),
        .par_en  (par_en),
        .par_odd (par_odd),
        .mode    (mode),
        .par_bad (par_bad)
    );

    rxerr_overrun u_overrun (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .shift_done (shift_done),
        .rx_trig_wr (rx_trig_wr),
        .buf_rd     (buf_rd),
        .ovr_hit    (ovr_hit)
    );

    always_comb begin
        buf_d       = buf_q;
        set_vec     = '0;
        if (shift_done) begin
            buf_d.data  = shift_data;
            set_vec.par = par_bad;
            set_vec.frm = !shift_stop;
        end
        set_vec.ovr = ovr_hit;
        set_vec.any = set_vec.par | set_vec.frm | set_vec.ovr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    rxerr_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (set_vec),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .flags      (flags)
    );

    assign rx_data = buf_q.data;
    assign par_err = flags.par;
    assign frm_err = flags.frm;
    assign ovr_err = flags.ovr;
    assign err_any = flags.any;
    assign err_irq = flags.any & irq_en;

endmodule

// File: rtl/rxerr_monitor_chk.sv
module rxerr_monitor_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              par_en,
    input logic              par_odd,
    input logic              irq_en,
    input logic              shift_done,
    input logic [DATA_W-1:0] shift_data,
    input logic              shift_stop,
    input logic              shift_par,
    input logic              rx_trig_wr,
    input logic              buf_rd,
    input logic              flag_wr,
    input logic [3:0]        flag_wdata,
    input logic [DATA_W-1:0] rx_data,
    input logic              par_err,
    input logic              frm_err,
    input logic              ovr_err,
    input logic              err_any,
    input logic              err_irq
);

    // R2
    data_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_done |=> rx_data == $past(shift_data));

    // R5
    stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_done && !shift_stop) |=> frm_err);

    // R4
    sync_no_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0 && !par_err) |=> !par_err);

    // R8
    master_no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'd1 || mode == 2'd3) && !ovr_err) |=> !ovr_err);

    // R9
    par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err && !(flag_wr && flag_wdata[0])) |=> par_err);

    // R11
    any_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(par_err) || $rose(frm_err) || $rose(ovr_err)) |-> err_any);

    // R12
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !err_irq);

endmodule

bind rxerr_monitor rxerr_monitor_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_rxerr_monitor.sv
module tb_rxerr_monitor;

    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic          par_en = 1'b0;
    logic          par_odd = 1'b0;
    logic          irq_en = 1'b0;
    logic          shift_done = 1'b0;
    logic [DW-1:0] shift_data = '0;
    logic          shift_stop = 1'b1;
    logic          shift_par = 1'b0;
    logic          rx_trig_wr = 1'b0;
    logic          buf_rd = 1'b0;
    logic          flag_wr = 1'b0;
    logic [3:0]    flag_wdata = '0;
    logic [DW-1:0] rx_data;
    logic          par_err, frm_err, ovr_err, err_any, err_irq;

    int n_total = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    rxerr_monitor #(.DATA_W(DW)) dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    // one clock: drive strobes, pass the edge, release strobes
    task automatic cyc(input logic done, input logic [DW-1:0] d, input logic stop,
                       input logic pb, input logic trig, input logic rd,
                       input logic wr, input logic [3:0] wd);
        shift_done = done; shift_data = d; shift_stop = stop; shift_par = pb;
        rx_trig_wr = trig; buf_rd = rd; flag_wr = wr; flag_wdata = wd;
        @(posedge clk);
        #1;
        shift_done = 1'b0; rx_trig_wr = 1'b0; buf_rd = 1'b0; flag_wr = 1'b0;
        flag_wdata = '0;
    endtask

    task automatic flags_are(input string req, input logic [3:0] exp);
        chk(req, {err_any, ovr_err, frm_err, par_err}, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 rx_data", rx_data, 0);
        flags_are("R1 flags", 4'b0000);
        chk("R1 irq", err_irq, 0);

        // R6 first character after reset, then one without a trigger
        mode = 2'd0;
        cyc(1, 4'h5, 1, 0, 0, 0, 0, 0);
        flags_are("R6 first char", 4'b0000);
        chk("R2 first data", rx_data, 4'h5);
        cyc(1, 4'hA, 1, 0, 0, 0, 0, 0);
        flags_are("R6 missing trigger", 4'b1100);
        // R12 gate
        chk("R12 irq disabled", err_irq, 0);
        irq_en = 1'b1; #1;
        chk("R12 irq enabled", err_irq, 1);
        // R9 writing zeros changes nothing
        cyc(0, 0, 1, 0, 0, 0, 1, 4'b0000);
        flags_are("R9 zero write", 4'b1100);
        // R11 clearing the overrun leaves the shared flag
        cyc(0, 0, 1, 0, 0, 0, 1, 4'b0100);
        flags_are("R11 any kept", 4'b1000);
        chk("R12 irq still", err_irq, 1);
        cyc(0, 0, 1, 0, 0, 0, 1, 4'b1000);
        flags_are("R9 any cleared", 4'b0000);
        chk("R12 irq low", err_irq, 0);

        // R7 coincident trigger after a proper handshake
        cyc(0, 0, 1, 0, 1, 0, 0, 0);
        cyc(1, 4'h3, 1, 0, 1, 0, 0, 0);
        flags_are("R7 coincident trigger", 4'b1100);
        // R10 detection beats same-cycle clear
        cyc(1, 4'h6, 1, 0, 0, 0, 1, 4'b1100);
        flags_are("R10 set over clear", 4'b1100);
        // R13 all three errors on one character
        cyc(0, 0, 1, 0, 0, 0, 1, 4'b1111);
        par_en = 1'b1; par_odd = 1'b0;
        cyc(1, 4'h1, 0, 0, 0, 0, 0, 0);
        flags_are("R13 triple error", 4'b1111);
        chk("R2 data with errors", rx_data, 4'h1);
        par_en = 1'b0;
        cyc(0, 0, 1, 0, 0, 0, 1, 4'b1111);

        // R8 slave mode handshake
        mode = 2'd2;
        cyc(0, 0, 1, 0, 0, 1, 0, 0);
        cyc(1, 4'h7, 1, 0, 0, 0, 0, 0);
        flags_are("R8 slave read before", 4'b0000);
        cyc(1, 4'h8, 1, 0, 1, 0, 0, 0);
        flags_are("R8 slave trigger ignored", 4'b1100);
        cyc(0, 0, 1, 0, 0, 0, 1, 4'b1111);
        cyc(1, 4'h9, 1, 0, 0, 1, 0, 0);
        flags_are("R8 slave read coincident", 4'b0000);
        // R8 master mode never overruns
        mode = 2'd1;
        cyc(1, 4'hB, 1, 0, 0, 0, 0, 0);
        cyc(1, 4'hC, 1, 0, 0, 0, 0, 0);
        flags_are("R8 master", 4'b0000);

        // R2 R3 R4 R5 exhaustive sweep
        for (int m = 0; m < 3; m++) begin
            for (int en = 0; en < 2; en++) begin
                for (int od = 0; od < 2; od++) begin
                    for (int d = 0; d < 16; d++) begin
                        for (int p = 0; p < 2; p++) begin
                            logic stop;
                            logic exp_par;
                            int ones;
                            mode = 2'(m); par_en = en[0]; par_odd = od[0];
                            stop = d[0] ^ p[0] ^ od[0];
                            ones = $countones(4'(d)) + p;
                            exp_par = (en == 1 && m == 0) && ((ones % 2) != od);
                            cyc(0, 0, 1, 0, 1, 1, 1, 4'b1111);
                            cyc(1, 4'(d), stop, p[0], 0, 0, 0, 0);
                            chk("R2 sweep data", rx_data, 32'(d));
                            chk(exp_par ? "R3 parity error" : "R4 parity quiet",
                                par_err, exp_par);
                            chk("R5 stop bit", frm_err, !stop);
                            chk("R11 shared flag", err_any, exp_par | !stop);
                            chk("R6 no overrun", ovr_err, 0);
                        end
                    end
                end
            end
        end
        report();
    end

endmodule